// File: doc/BRIEF.md
# Bit Counting Unit

This block is a purely combinational execution unit for a processor integer datapath. It takes one source register value and returns one of three counts: the run of zeros from the most significant end, the run of zeros from the least significant end, or the number of set bits. The count is zero-extended to the register width. When the datapath is 64 bits wide, each count also has a 32-bit word form. The word forms read only the low 32 bits of the register.

The word forms do not have a 32-bit datapath of their own. The operand is conditioned in front of the same full-width counters: it is moved up, padded with ones, or masked, so that the full-width count returns the word answer and can never exceed 32. A separate legality stage raises an illegal flag and clears the result in three cases: the extension is disabled, the operation code is reserved, or a word form is requested on a 32-bit datapath.

Top module: `bitcount_unit`

## Requirements
- R1: With op code 0 and word mode off, the result is the number of zero bits above the highest set bit of the operand, and XLEN when the operand is zero.
- R2: With op code 1 and word mode off, the result is the number of zero bits below the lowest set bit of the operand, and XLEN when the operand is zero.
- R3: With op code 2 and word mode off, the result is the number of set bits in the whole operand.
- R4: With op code 0 and word mode on (XLEN 64), only bits 31..0 are examined: the result is the number of zeros above the highest set bit within that word, and 32 when bits 31..0 are all zero.
- R5: With op code 1 and word mode on (XLEN 64), bits 63..32 have no effect: the result counts zeros upward from bit 0 and never exceeds 32.
- R6: With op code 2 and word mode on (XLEN 64), the result counts set bits in bits 31..0 only.
- R7: With XLEN 32, any request with word mode on raises the illegal flag and drives a result of zero.
- R8: When the extension enable is low, every operation raises the illegal flag and drives a result of zero.
- R9: Op code 3 is reserved: it raises the illegal flag and drives a result of zero.
- R10: For a legal request the illegal flag is low, and all result bits above the count width ($clog2(XLEN+1) bits) are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | XLEN | Source register value |
| op_i | input | 2 | Operation: 0 leading zeros, 1 trailing zeros, 2 set bits, 3 reserved |
| word_i | input | 1 | Selects the 32-bit word form |
| ext_en_i | input | 1 | Enables the unit's operations |
| result_o | output | XLEN | Zero-extended count, zero when illegal |
| illegal_o | output | 1 | High when the request is not allowed |

## Verification
The unit holds no state, so any fault in the operand conditioning or in a counter shows at the ports in the same cycle as the operand that exposes it. A missing pad in the word leading-zero path returns 64 instead of 32 on a zero low word. A missing mask lets upper-half bits change a word trailing count or a word population count. Single-bit operands at every position, together with all-zero, all-one and split-half operands, drive each counter across its full range. Comparing against a bit-by-bit loop model catches an off-by-one in either scan direction at once.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    typedef enum logic [1:0] {
        BC_LEAD  = 2'd0,
        BC_TRAIL = 2'd1,
        BC_POP   = 2'd2,
        BC_RSVD  = 2'd3
    } bc_op_e;

    localparam int WORD_W = 32;

    typedef struct packed {
        bc_op_e op;
        logic   word;
        logic   en;
    } bc_req_t;

    function automatic int cnt_w(input int w);
        return $clog2(w + 1);
    endfunction

    function automatic bit word_capable(input int xlen);
        return xlen == 64;
    endfunction

endpackage

// File: rtl/bcu_operand_prep.sv
module bcu_operand_prep
    import bcu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opnd_i,
    input  logic            word_i,
    output logic [XLEN-1:0] lead_vec_o,
    output logic [XLEN-1:0] trail_vec_o,
    output logic [XLEN-1:0] pop_vec_o
);

    localparam int UPPER_W = XLEN - WORD_W;

    generate
        if (word_capable(XLEN)) begin : g_word
            // Move the low word to the top. A single marker one just below it
            // caps the leading count at 32 when the word is empty.
            logic [XLEN-1:0] lead_word;
            logic [XLEN-1:0] trail_word;
            logic [XLEN-1:0] pop_word;

            assign lead_word  = {opnd_i[WORD_W-1:0], 1'b1, {(UPPER_W-1){1'b0}}};
            assign trail_word = {{UPPER_W{1'b1}}, opnd_i[WORD_W-1:0]};
            assign pop_word   = {{UPPER_W{1'b0}}, opnd_i[WORD_W-1:0]};

            assign lead_vec_o  = word_i ? lead_word  : opnd_i;
            assign trail_vec_o = word_i ? trail_word : opnd_i;
            assign pop_vec_o   = word_i ? pop_word   : opnd_i;
        end else begin : g_full_only
            // Word requests are rejected by the guard; keep the counters quiet.
            assign lead_vec_o  = word_i ? '0 : opnd_i;
            assign trail_vec_o = word_i ? '0 : opnd_i;
            assign pop_vec_o   = word_i ? '0 : opnd_i;
        end
    endgenerate

endmodule

// File: rtl/bcu_lead_count.sv
module bcu_lead_count
    import bcu_pkg::*;
#(
    parameter int W = 64,
    localparam int CW = cnt_w(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    always_comb begin
        cnt_o = CW'(W);
        // The highest set bit is visited last and so wins.
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                cnt_o = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/bcu_trail_count.sv
module bcu_trail_count
    import bcu_pkg::*;
#(
    parameter int W = 64,
    localparam int CW = cnt_w(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    logic [W-1:0] mirrored;

    generate
        for (genvar g = 0; g < W; g++) begin : g_mirror
            assign mirrored[g] = vec_i[W-1-g];
        end
    endgenerate

    bcu_lead_count #(.W(W)) u_scan (
        .vec_i (mirrored),
        .cnt_o (cnt_o)
    );

endmodule

// File: rtl/bcu_pop_count.sv
module bcu_pop_count
    import bcu_pkg::*;
#(
    parameter int W = 64,
    localparam int CW = cnt_w(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end

endmodule

// File: rtl/bcu_guard.sv
module bcu_guard
    import bcu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  bc_req_t req_i,
    output logic    illegal_o
);

    localparam bit WORD_OK = word_capable(XLEN);

    logic bad_word;
    logic bad_op;

    assign bad_word  = req_i.word && !WORD_OK;
    assign bad_op    = (req_i.op == BC_RSVD);
    assign illegal_o = !req_i.en || bad_op || bad_word;

endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
    import bcu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opnd_i,
    input  logic [1:0]      op_i,
    input  logic            word_i,
    input  logic            ext_en_i,
    output logic [XLEN-1:0] result_o,
    output logic            illegal_o
);

    localparam int CW = cnt_w(XLEN);

    bc_req_t         req;
    logic [XLEN-1:0] lead_vec;
    logic [XLEN-1:0] trail_vec;
    logic [XLEN-1:0] pop_vec;
    logic [CW-1:0]   lead_cnt;
    logic [CW-1:0]   trail_cnt;
    logic [CW-1:0]   pop_cnt;
    logic [CW-1:0]   sel_cnt;
    logic            bad;

    assign req.op   = bc_op_e'(op_i);
    assign req.word = word_i;
    assign req.en   = ext_en_i;

    bcu_guard #(.XLEN(XLEN)) u_guard (
        .req_i     (req),
        .illegal_o (bad)
    );

    bcu_operand_prep #(.XLEN(XLEN)) u_prep (
        .opnd_i      (opnd_i),
        .word_i      (word_i),
        .lead_vec_o  (lead_vec),
        .trail_vec_o (trail_vec),
        .pop_vec_o   (pop_vec)
    );

    bcu_lead_count  #(.W(XLEN)) u_lead  (.vec_i(lead_vec),  .cnt_o(lead_cnt));
    bcu_trail_count #(.W(XLEN)) u_trail (.vec_i(trail_vec), .cnt_o(trail_cnt));
    bcu_pop_count   #(.W(XLEN)) u_pop   (.vec_i(pop_vec),   .cnt_o(pop_cnt));

    always_comb begin
        unique case (req.op)
            BC_LEAD:  sel_cnt = lead_cnt;
            BC_TRAIL: sel_cnt = trail_cnt;
            BC_POP:   sel_cnt = pop_cnt;
            default:  sel_cnt = '0;
        endcase
    end

    assign result_o  = bad ? '0 : {{(XLEN-CW){1'b0}}, sel_cnt};
    assign illegal_o = bad;

endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
    parameter int XLEN = 64
) (
    input logic [XLEN-1:0] opnd_i,
    input logic [1:0]      op_i,
    input logic            word_i,
    input logic            ext_en_i,
    input logic [XLEN-1:0] result_o,
    input logic            illegal_o
);

    localparam int CW = $clog2(XLEN + 1);

    always_comb begin
        if (!$isunknown({opnd_i, op_i, word_i, ext_en_i, result_o, illegal_o})) begin
            // R8: disabled extension always flags
            p_disabled_flags_r8: assert (ext_en_i || illegal_o)
                else $error("disabled request not flagged");
            // R9: reserved code always flags
            p_reserved_flags_r9: assert (op_i != 2'd3 || illegal_o)
                else $error("reserved op not flagged");
            // R7: a flagged request carries no result
            p_no_result_r7: assert (!illegal_o || result_o == '0)
                else $error("illegal request produced a result");
            // R5: word counts never exceed 32
            p_word_cap_r5: assert (illegal_o || !word_i || result_o <= XLEN'(32))
                else $error("word count above 32");
            // R10: bits above the count field are zero
            p_zero_ext_r10: assert (result_o[XLEN-1:CW] == '0)
                else $error("result not zero-extended");
            // R3: full population count matches the operand
            p_full_pop_r3: assert (illegal_o || word_i || op_i != 2'd2
                                   || result_o == XLEN'($countones(opnd_i)))
                else $error("population count mismatch");
        end
    end

endmodule

bind bitcount_unit bcu_checker #(.XLEN(XLEN)) u_chk (
    .opnd_i    (opnd_i),
    .op_i      (op_i),
    .word_i    (word_i),
    .ext_en_i  (ext_en_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
);

// File: tb/bitcount_unit_test.sv
`timescale 1ns/1ps
module bitcount_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [63:0] a   = '0;
    logic [1:0]  op  = '0;
    logic        wd  = 1'b0;
    logic        en  = 1'b0;
    logic [63:0] res;
    logic        ill;
    logic [31:0] a32 = '0;
    logic [31:0] res32;
    logic        ill32;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    bitcount_unit #(.XLEN(64)) uut (
        .opnd_i(a), .op_i(op), .word_i(wd), .ext_en_i(en),
        .result_o(res), .illegal_o(ill)
    );

    bitcount_unit #(.XLEN(32)) uut32 (
        .opnd_i(a32), .op_i(op), .word_i(wd), .ext_en_i(en),
        .result_o(res32), .illegal_o(ill32)
    );

    function automatic logic [63:0] ref_model(input logic [63:0] v, input int o,
                                              input bit w, input bit e,
                                              input int xl, output bit bad);
        int n;
        int c;
        bad = !e || (o == 3) || (w && xl != 64);
        if (bad) return '0;
        n = w ? 32 : xl;
        c = 0;
        if (o == 0) begin
            c = n;
            for (int i = 0; i < n; i++) if (v[i]) c = n - 1 - i;
        end else if (o == 1) begin
            c = n;
            for (int i = n - 1; i >= 0; i--) if (v[i]) c = i;
        end else begin
            for (int i = 0; i < n; i++) c += int'(v[i]);
        end
        return 64'(c);
    endfunction

    task automatic check(input logic [63:0] v, input int o, input bit w,
                         input bit e, input string tag);
        logic [63:0] exp64;
        logic [63:0] exp32;
        bit          bad64;
        bit          bad32;
        string       tag32;
        @(negedge clk);
        a = v; a32 = v[31:0]; op = 2'(o); wd = w; en = e;
        #1;
        exp64 = ref_model(v, o, w, e, 64, bad64);
        exp32 = ref_model({32'b0, v[31:0]}, o, w, e, 32, bad32);
        tag32 = w ? "R7" : tag;
        checks++;
        if (res !== exp64 || ill !== bad64) begin
            errors++;
            $display("FAIL %s xlen64 op=%0d w=%0d v=%h: got res=%0d ill=%0d exp res=%0d ill=%0d",
                     tag, o, w, v, res, ill, exp64, bad64);
        end
        checks++;
        if (res32 !== exp32[31:0] || ill32 !== bad32) begin
            errors++;
            $display("FAIL %s xlen32 op=%0d w=%0d v=%h: got res=%0d ill=%0d exp res=%0d ill=%0d",
                     tag32, o, w, v[31:0], res32, ill32, exp32[31:0], bad32);
        end
        if (!bad64) begin
            checks++;
            if (res[63:7] !== '0) begin
                errors++;
                $display("FAIL R10 upper result bits: got %h exp 0", res[63:7]);
            end
        end
    endtask

    function automatic string tag_of(input int o, input bit w);
        if (o == 3) return "R9";
        if (w) return (o == 0) ? "R4" : (o == 1) ? "R5" : "R6";
        return (o == 0) ? "R1" : (o == 1) ? "R2" : "R3";
    endfunction

    task automatic t_idle;
        check(64'h0, 0, 0, 0, "R8");
    endtask

    task automatic t_extremes;
        for (int o = 0; o < 3; o++) begin
            for (int w = 0; w < 2; w++) begin
                check(64'h0, o, w[0], 1, tag_of(o, w[0]));
                check('1, o, w[0], 1, tag_of(o, w[0]));
            end
        end
    endtask

    task automatic t_single_bits;
        for (int b = 0; b < 64; b++) begin
            for (int o = 0; o < 3; o++) begin
                check(64'h1 << b, o, 0, 1, tag_of(o, 0));
                check(64'h1 << b, o, 1, 1, tag_of(o, 1));
            end
        end
    endtask

    task automatic t_word_upper;
        check(64'hFFFF_FFFF_0000_0000, 0, 1, 1, "R4");
        check(64'hFFFF_FFFF_0000_0000, 1, 1, 1, "R5");
        check(64'hFFFF_FFFF_0000_0000, 2, 1, 1, "R6");
        check(64'h8000_0001_0000_0010, 0, 1, 1, "R4");
        check(64'h8000_0001_0000_0010, 1, 1, 1, "R5");
        check(64'h8000_0001_0000_0010, 2, 1, 1, "R6");
        check(64'h0000_0000_FFFF_FFFF, 0, 0, 1, "R1");
        check(64'h0000_0000_0000_0000, 1, 1, 1, "R5");
    endtask

    task automatic t_disabled;
        for (int o = 0; o < 4; o++) begin
            check(64'h0123_4567_89AB_CDEF, o, 0, 0, "R8");
            check(64'h0123_4567_89AB_CDEF, o, 1, 0, "R8");
        end
    endtask

    task automatic t_reserved;
        check(64'hDEAD_BEEF_0000_0001, 3, 0, 1, "R9");
        check(64'h0, 3, 1, 1, "R9");
    endtask

    task automatic t_patterns;
        logic [63:0] lfsr = 64'hACE1_2468_1357_9BDF;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            for (int o = 0; o < 3; o++) begin
                check(lfsr >> (k % 7), o, 0, 1, tag_of(o, 0));
                check(lfsr << (k % 5), o, 1, 1, tag_of(o, 1));
            end
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got cycles=%0d exp completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_extremes();
        t_single_bits();
        t_word_upper();
        t_disabled();
        t_reserved();
        t_patterns();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule